// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block generates a gated, divided core clock for a peripheral from one fast timing input. The input `ref2x_clk` runs at twice the reference frequency, so one of its cycles lasts exactly one half-period of the reference. The block first chooses a prestage source: the reference divided by 16, 4 or 2, or the undivided reference. It then divides that source by an integer ratio N = field + 1. When the half-step bit is set, the ratio becomes N + 0.5. All internal logic runs in the `ref2x_clk` domain and uses clock enables. The output is a registered signal.

Software programs one 32-bit configuration word over a simple write-strobe bus. The enable bit takes effect at once. The source, half-step and divide fields are latched into the running divider only at the start of an output period, so reprogramming never produces a short pulse. A divide field of zero (ratio 1) is not a legal setting and its behaviour is left undefined.

Top module: `hdiv_clkgen`

## Requirements
- R1: After reset the configuration word reads 0x00000001 (disabled, source code 00, integer mode, field 1) and `clk_out` is low.
- R2: Configuration layout: bit 31 is the enable, bits 18:17 are the source code, bit 16 is the half-step flag and bits 15:0 are the divide field. All other bits read as zero. A write is visible on `cfg_rdata` from the cycle after the write strobe.
- R3: While the enable is clear, `clk_out` is low, and the prescaler and period counter are held. After a write that clears the enable, `clk_out` is low from the second `ref2x_clk` edge onward.
- R4: The source code sets the source half-period H in `ref2x_clk` cycles: 00 gives H=16, 01 gives H=4, 10 gives H=2 and 11 gives H=1.
- R5: In integer mode the output period is 2·N·H cycles, where N = field + 1.
- R6: In integer mode the high phase is 2·ceil(N/2)·H cycles. For odd N the high phase is one source period longer than the low phase; for even N the two phases are equal.
- R7: In half-step mode the output period is (2·N+1)·H cycles and the high phase is (N+1)·H cycles.
- R8: A write that sets the enable makes `clk_out` rise at the second `ref2x_clk` edge after the write strobe. The first period after enabling has full length.
- R9: A write made while the divider runs changes neither the current period nor its high phase. The new source, half-step and divide values apply from the next period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref2x_clk | input | 1 | Timing input at twice the reference frequency |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
The bench measures every output period and high phase against values it predicts for each of the four sources, in both modes, with odd and even ratios. A wrong tap would scale all periods by the wrong factor. An off-by-one in the half-step count would make the period 2N or 2N+2. A symmetric split for odd ratios would show a high phase shortened by one source period. A write issued in the middle of a period must leave that period intact: a design that loads fields at once would produce a truncated or stretched period. The bench also checks enable and disable latency, and that `clk_out` stays low while the register holds every field bit set except the enable.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
   localparam int CFG_W    = 32;
   localparam int EN_BIT   = 31;
   localparam int SRC_LO   = 17;
   localparam int HALF_BIT = 16;
   localparam int NUM_SRC  = 4;

   typedef enum logic [1:0] {
      SRC_DIV16  = 2'b00,
      SRC_DIV4   = 2'b01,
      SRC_DIV2   = 2'b10,
      SRC_DIRECT = 2'b11
   } src_e;

   // log2 of the half-period, in base cycles, for each source code
   function automatic int src_shift(input int code);
      case (code)
         0: return 4;
         1: return 2;
         2: return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/hdiv_cfg_reg.sv
module hdiv_cfg_reg
   import hdiv_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output logic             en,
   output src_e             src,
   output logic             half,
   output logic [DIV_W-1:0] div
);
   generate
      if (DIV_W < 2 || DIV_W > HALF_BIT) begin : g_bad_w
         $error("hdiv_cfg_reg: DIV_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         src  <= SRC_DIV16;
         half <= 1'b0;
         div  <= DIV_W'(1);
      end else if (we) begin
         en   <= wdata[EN_BIT];
         src  <= src_e'(wdata[SRC_LO+1:SRC_LO]);
         half <= wdata[HALF_BIT];
         div  <= wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      rdata                   = '0;
      rdata[EN_BIT]           = en;
      rdata[SRC_LO+1:SRC_LO]  = src;
      rdata[HALF_BIT]         = half;
      rdata[DIV_W-1:0]        = div;
   end
endmodule

// File: rtl/hdiv_prescaler.sv
module hdiv_prescaler
   import hdiv_pkg::*;
#(
   parameter int PRE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  src_e src,
   output logic tick
);
   localparam int MAX_SH = src_shift(0);

   generate
      if (PRE_W < MAX_SH) begin : g_bad_pre
         $error("hdiv_prescaler: PRE_W too small for the slowest source");
      end
   endgenerate

   logic [PRE_W-1:0]   pre_q;
   logic [NUM_SRC-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (!run || restart)  pre_q <= '0;
      else                       pre_q <= pre_q + PRE_W'(1);
   end

   // one tap per source: true on the last base cycle of each half-period
   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_tap
         localparam int SH = src_shift(g);
         if (SH == 0) begin : g_direct
            assign tap[g] = 1'b1;
         end else begin : g_count
            assign tap[g] = &pre_q[SH-1:0];
         end
      end
   endgenerate

   assign tick = run & tap[src];
endmodule

// File: rtl/hdiv_phase_ctr.sv
module hdiv_phase_ctr
   import hdiv_pkg::*;
#(
   parameter int DIV_W = 16,
   localparam int CNT_W = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  src_e             src_in,
   input  logic             half_in,
   input  logic [DIV_W-1:0] div_in,
   input  logic             tick,
   output logic             run,
   output src_e             src_act,
   output logic             restart,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] per,
   output logic             out
);
   logic             half_act;
   logic [DIV_W-1:0] div_act;
   logic [CNT_W-1:0] n_ext, high, cnt_nx;
   logic             last;

   always_comb begin
      n_ext  = CNT_W'(div_act) + CNT_W'(1);
      per    = half_act ? ((n_ext << 1) + CNT_W'(1)) : (n_ext << 1);
      high   = half_act ? (n_ext + CNT_W'(1))
                        : (((n_ext + CNT_W'(1)) >> 1) << 1);
      last   = (cnt == per - CNT_W'(1));
      cnt_nx = cnt + CNT_W'(1);
   end

   assign restart = tick & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         cnt      <= '0;
         out      <= 1'b0;
         src_act  <= SRC_DIV16;
         half_act <= 1'b0;
         div_act  <= DIV_W'(1);
      end else if (!en) begin
         run      <= 1'b0;
         cnt      <= '0;
         out      <= 1'b0;
         src_act  <= src_in;
         half_act <= half_in;
         div_act  <= div_in;
      end else if (!run) begin
         run      <= 1'b1;
         cnt      <= '0;
         out      <= 1'b1;
         src_act  <= src_in;
         half_act <= half_in;
         div_act  <= div_in;
      end else if (tick) begin
         if (last) begin
            cnt      <= '0;
            out      <= 1'b1;
            src_act  <= src_in;
            half_act <= half_in;
            div_act  <= div_in;
         end else begin
            cnt <= cnt_nx;
            out <= (cnt_nx < high);
         end
      end
   end
endmodule

// File: rtl/hdiv_clkgen.sv
module hdiv_clkgen
   import hdiv_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int PRE_W = 4
) (
   input  logic        ref2x_clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        clk_out
);
   localparam int CNT_W = DIV_W + 2;

   logic             cfg_en, cfg_half, tick, run, restart;
   src_e             cfg_src, src_act;
   logic [DIV_W-1:0] cfg_div;
   logic [CNT_W-1:0] cnt, per;

   hdiv_cfg_reg #(.DIV_W(DIV_W)) u_reg (
      .clk(ref2x_clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .en(cfg_en), .src(cfg_src), .half(cfg_half),
      .div(cfg_div)
   );

   hdiv_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(ref2x_clk), .rst_n(rst_n), .run(run), .restart(restart),
      .src(src_act), .tick(tick)
   );

   hdiv_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
      .clk(ref2x_clk), .rst_n(rst_n), .en(cfg_en), .src_in(cfg_src),
      .half_in(cfg_half), .div_in(cfg_div), .tick(tick), .run(run),
      .src_act(src_act), .restart(restart), .cnt(cnt), .per(per),
      .out(clk_out)
   );
endmodule

// File: rtl/hdiv_clkgen_chk.sv
module hdiv_clkgen_chk #(
   parameter int DIV_W = 16,
   localparam int CNT_W = DIV_W + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [31:0]      cfg_wdata,
   input logic [31:0]      cfg_rdata,
   input logic             clk_out,
   input logic             cfg_en,
   input logic             run,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per
);
   localparam logic [31:0] MASK = 32'h8007_0000 | ((32'h1 << DIV_W) - 32'h1);

   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & MASK)));

   assert_gated_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !clk_out);

   assert_rise_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> $past(cfg_en));

   assert_edge_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cfg_en && !tick) |=> $stable(clk_out));

   assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < per));
endmodule

bind hdiv_clkgen hdiv_clkgen_chk #(.DIV_W(DIV_W)) chk_i (
   .clk(ref2x_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata), .clk_out(clk_out), .cfg_en(cfg_en), .run(run),
   .tick(tick), .cnt(cnt), .per(per)
);

// File: tb/hdiv_clkgen_tb_top.sv
module hdiv_clkgen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   wire  [31:0] rdata;
   wire         clk_out;

   always #10 clk = ~clk;

   hdiv_clkgen dut_i (
      .ref2x_clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata),
      .cfg_rdata(rdata), .clk_out(clk_out)
   );

   typedef struct { int high; int per; string tag; } exp_t;
   exp_t q[$];

   int n_chk = 0, n_fail = 0, cyc = 0;
   int t_rise = 0, t_fall = 0;
   bit have_start = 0, done = 0;
   logic prev = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // monitor: measures each full period and compares with the queue front
   always @(negedge clk) begin
      cyc++;
      if (clk_out && !prev) begin
         if (have_start && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check((t_fall - t_rise) == e.high, e.tag, "high", t_fall - t_rise, e.high);
            check((cyc - t_rise) == e.per, e.tag, "period", cyc - t_rise, e.per);
         end
         have_start = 1;
         t_rise = cyc;
      end
      if (!clk_out && prev) t_fall = cyc;
      prev = clk_out;
   end

   function automatic logic [31:0] word(input bit en, input int src,
                                        input bit half, input int div);
      return {en, 12'd0, 2'(src), half, 16'(div)};
   endfunction

   function automatic int hper(input int src);
      case (src) 0: return 16; 1: return 4; 2: return 2; default: return 1; endcase
   endfunction

   function automatic int e_per(input int src, input bit half, input int div);
      int n = div + 1;
      return half ? (2 * n + 1) * hper(src) : 2 * n * hper(src);
   endfunction

   function automatic int e_high(input int src, input bit half, input int div);
      int n = div + 1;
      return half ? (n + 1) * hper(src) : 2 * ((n + 1) / 2) * hper(src);
   endfunction

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic push(input int src, input bit half, input int div,
                       input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.high = e_high(src, half, div);
         e.per  = e_per(src, half, div);
         e.tag  = tag;
         q.push_back(e);
      end
   endtask

   task automatic stop_run();
      wr(word(0, 0, 0, 1));
      repeat (3) @(negedge clk);
      have_start = 0;
   endtask

   task automatic run_case(input int src, input bit half, input int div,
                           input string tag);
      stop_run();
      push(src, half, div, 3, tag);
      wr(word(1, src, half, div));
      while (q.size() > 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(rdata == 32'h0000_0001, "R1", "reset word", rdata, 32'h1);
      check(clk_out == 1'b0, "R1", "reset out", clk_out, 0);
      rst_n = 1'b1;

      // all fields set except enable: reserved bits read zero, output held low
      wr(32'h7FFF_FFFF);
      check(rdata == 32'h0007_FFFF, "R2", "readback", rdata, 32'h0007_FFFF);
      begin
         int hi = 0;
         for (int i = 0; i < 60; i++) begin @(negedge clk); hi += clk_out; end
         check(hi == 0, "R3", "disabled high samples", hi, 0);
      end

      // sources and integer ratios (odd and even N)
      run_case(0, 0, 1, "R4");
      run_case(1, 0, 2, "R6");
      run_case(2, 0, 3, "R5");
      run_case(3, 0, 4, "R6");
      run_case(3, 0, 999, "R5");
      // half-step ratios
      run_case(2, 1, 1, "R7");
      run_case(3, 1, 4, "R7");
      run_case(0, 1, 2, "R7");
      run_case(1, 1, 6, "R7");

      // enable latency: write at edge E0, output rises at E1
      stop_run();
      @(negedge clk);
      we = 1'b1; wdata = word(1, 3, 0, 3);
      @(negedge clk);
      we = 1'b0;
      check(clk_out == 1'b0, "R8", "out one edge after write", clk_out, 0);
      @(negedge clk);
      check(clk_out == 1'b1, "R8", "out two edges after write", clk_out, 1);
      repeat (2) @(negedge clk);
      // disable latency while high
      we = 1'b1; wdata = word(0, 3, 0, 3);
      @(negedge clk);
      we = 1'b0;
      @(negedge clk);
      check(clk_out == 1'b0, "R3", "out after disable", clk_out, 0);
      begin
         int hi = 0;
         for (int i = 0; i < 100; i++) begin @(negedge clk); hi += clk_out; end
         check(hi == 0, "R3", "high samples after disable", hi, 0);
      end

      // reprogramming mid-period takes effect at the boundary
      stop_run();
      push(3, 0, 2, 2, "R9");
      push(3, 1, 4, 2, "R9");
      wr(word(1, 3, 0, 2));
      while (q.size() > 3) @(negedge clk);
      wr(word(1, 3, 1, 4));
      while (q.size() > 0) @(negedge clk);

      // source change at the boundary
      stop_run();
      push(1, 0, 1, 2, "R9");
      push(0, 0, 1, 2, "R9");
      wr(word(1, 1, 0, 1));
      while (q.size() > 3) @(negedge clk);
      wr(word(1, 0, 0, 1));
      while (q.size() > 0) @(negedge clk);

      stop_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule